// File: doc/BRIEF.md
# Pulse-Distance OOK Frame Decoder

This block sits behind an on-off keyed radio demodulator. Its input is the raw data line, with no recovered clock. Each bit is carried by the time from one pulse's rising edge to the next. The block measures that distance in system clock cycles and classifies it as a 0 (short) or a 1 (long). It then searches for a preamble of four consecutive ones and collects the rest of the frame. A frame is 46 bits: the 4 preamble ones, a 40-bit payload and 2 trailing bits. The first decoded bit ends up in the most significant position.

A transmitter repeats every frame six times for each event. When a frame completes, the block raises a one-cycle `frame_valid` strobe and holds the frame stable on `frame_data`. When a frame equals the one decoded just before it, the block raises `frame_confirmed` once for that burst. The glitch limit, the short/long split and the silence timeout are inputs. The burst separation is a parameter.

The frame assembler is a three-state machine. ST_HUNT counts consecutive ones and restarts the count on a zero. The fourth one takes the transition "preamble found" to ST_PAYLOAD. ST_PAYLOAD shifts in bits. An abort takes the transition "silence timeout" back to ST_HUNT. The 46th bit takes the transition "frame complete" to ST_EMIT. ST_EMIT lasts one cycle and then takes the transition "strobe done" back to ST_HUNT.

Top module: `ppd_decoder`

## Requirements
- R1: A gap D, measured in cycles between rising edges of `rx_in`, with cfg_glitch <= D < cfg_timeout, decodes as 0 when D < cfg_split and as 1 when D >= cfg_split.
- R2: A rising edge that arrives fewer than cfg_glitch cycles after the last accepted edge is ignored. The gap keeps being measured from the earlier edge.
- R3: If no accepted edge arrives for cfg_timeout cycles, any partial frame is dropped and the decoder returns to preamble search. The next edge starts a new measurement.
- R4: Assembly starts only after four consecutive 1 symbols. A 0 restarts the count. Symbols before the preamble are not kept, and bits 45:42 of every frame are 1111.
- R5: Bits are shifted in most significant first. The first preamble bit appears at `frame_data[45]` and the last decoded bit at `frame_data[0]`.
- R6: On the 46th bit, `frame_valid` is high for exactly one cycle, with the new frame on `frame_data`. `frame_data` changes only in that cycle.
- R7: `frame_confirmed` pulses for one cycle, in the cycle after `frame_valid`, when the new frame equals the frame decoded before it in the same burst. A single frame, or two different frames in a row, gives no confirmation.
- R8: Within one burst, further identical repeats do not confirm again. The decoder re-arms after a differing frame, or after BURST_IDLE cycles with no completed frame.
- R9: After reset, `frame_valid`, `frame_confirmed` and `frame_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in | input | 1 | Asynchronous demodulated data line, idle low |
| cfg_glitch | input | CNT_W | Minimum accepted edge-to-edge gap |
| cfg_split | input | CNT_W | Gaps at or above this value decode as 1 |
| cfg_timeout | input | CNT_W | Silence length that aborts a frame |
| frame_valid | output | 1 | One-cycle strobe: a frame has completed |
| frame_data | output | FRAME_BITS | Last completed frame, held until the next one |
| frame_confirmed | output | 1 | One-cycle strobe: a repeat matched |

## Verification
The assertions assume three things about the inputs. First, the configuration holds still and is ordered so that cfg_glitch is at least 2 and below cfg_split, and cfg_split is below cfg_timeout. Second, a complete frame needs at least 47 accepted edges, so two frame strobes cannot fall on neighbouring cycles. Third, frames of a burst arrive closer together than BURST_IDLE.

The stimulus keeps within these limits in the following way. It uses fixed settings of 6, 20 and 60 cycles. Pulses are 3 cycles high, and gaps are 12 or 28 cycles, or 19 and 20 at the threshold. Glitch pulses fall 4 cycles after a real edge. Every frame is followed by a silence longer than the timeout, and each scenario starts after a wait longer than BURST_IDLE.

// File: rtl/ppd_pkg.sv
package ppd_pkg;
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_PAYLOAD = 2'd1,
        ST_EMIT    = 2'd2
    } dec_state_e;
endpackage

// File: rtl/ppd_edge_sync.sv
module ppd_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    output logic rise
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= rx_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/ppd_gap_timer.sv
module ppd_gap_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic [CNT_W-1:0] cfg_glitch,
    input  logic [CNT_W-1:0] cfg_split,
    input  logic [CNT_W-1:0] cfg_timeout,
    output logic             sym_valid,
    output logic             sym_bit,
    output logic             abort
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             armed;
    logic [CNT_W-1:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            gap_cnt   <= '0;
            sym_valid <= 1'b0;
            sym_bit   <= 1'b0;
            abort     <= 1'b0;
        end else begin
            sym_valid <= 1'b0;
            abort     <= 1'b0;
            if (rise) begin
                if (!armed) begin
                    armed   <= 1'b1;
                    gap_cnt <= ONE;
                end else if (gap_cnt >= cfg_timeout) begin
                    abort   <= 1'b1;
                    gap_cnt <= ONE;
                end else if (gap_cnt < cfg_glitch) begin
                    gap_cnt <= gap_cnt + ONE;      // noise edge: keep measuring
                end else begin
                    sym_valid <= 1'b1;
                    sym_bit   <= (gap_cnt >= cfg_split);
                    gap_cnt   <= ONE;
                end
            end else if (armed) begin
                if (gap_cnt >= cfg_timeout) begin
                    abort <= 1'b1;
                    armed <= 1'b0;
                end else begin
                    gap_cnt <= gap_cnt + ONE;
                end
            end
        end
    end

    // R3: a timeout never coincides with a decoded symbol
    assert_sym_not_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> !abort);
endmodule

// File: rtl/ppd_frame_asm.sv
module ppd_frame_asm
    import ppd_pkg::*;
#(
    parameter int FRAME_BITS = 46,
    parameter int PRE_BITS   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sym_valid,
    input  logic                  sym_bit,
    input  logic                  abort,
    output logic                  frame_valid,
    output logic [FRAME_BITS-1:0] frame_data
);
    localparam int BW = $clog2(FRAME_BITS + 1);
    localparam int OW = $clog2(PRE_BITS + 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);
    localparam logic [BW-1:0] PRE_CNT  = BW'(PRE_BITS);
    localparam logic [OW-1:0] LAST_ONE = OW'(PRE_BITS - 1);

    dec_state_e             state, state_nx;
    logic [OW-1:0]          ones_cnt;
    logic [BW-1:0]          bit_cnt;
    logic [FRAME_BITS-1:0]  shreg;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT:
                if (sym_valid && sym_bit && ones_cnt == LAST_ONE)
                    state_nx = ST_PAYLOAD;               // preamble found
            ST_PAYLOAD:
                if (abort)
                    state_nx = ST_HUNT;                  // silence timeout
                else if (sym_valid && bit_cnt == LAST_BIT)
                    state_nx = ST_EMIT;                  // frame complete
            ST_EMIT:
                state_nx = ST_HUNT;                      // strobe done
            default:
                state_nx = ST_HUNT;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_cnt   <= '0;
            bit_cnt    <= '0;
            shreg      <= '0;
            frame_data <= '0;
        end else begin
            unique case (state)
                ST_HUNT: begin
                    if (abort || (sym_valid && !sym_bit)) begin
                        ones_cnt <= '0;
                    end else if (sym_valid) begin
                        if (ones_cnt == LAST_ONE) begin
                            ones_cnt <= '0;
                            shreg    <= '1;
                            bit_cnt  <= PRE_CNT;
                        end else begin
                            ones_cnt <= ones_cnt + OW'(1);
                        end
                    end
                end
                ST_PAYLOAD: begin
                    if (sym_valid) begin
                        shreg   <= {shreg[FRAME_BITS-2:0], sym_bit};
                        bit_cnt <= bit_cnt + BW'(1);
                        if (bit_cnt == LAST_BIT)
                            frame_data <= {shreg[FRAME_BITS-2:0], sym_bit};
                    end
                end
                ST_EMIT: begin
                    ones_cnt <= '0;
                end
                default: ;
            endcase
        end
    end

    assign frame_valid = (state == ST_EMIT);

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);
    assert_data_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_data != $past(frame_data)) |-> frame_valid);
    assert_preamble_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (frame_data[FRAME_BITS-1 -: PRE_BITS] == '1));
endmodule

// File: rtl/ppd_repeat_check.sv
module ppd_repeat_check #(
    parameter int FRAME_BITS = 46,
    parameter int BURST_IDLE = 50000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_valid,
    input  logic [FRAME_BITS-1:0] frame_data,
    output logic                  frame_confirmed
);
    localparam int IW = $clog2(BURST_IDLE + 1);
    localparam logic [IW-1:0] IDLE_LIM = IW'(BURST_IDLE);

    logic [FRAME_BITS-1:0] prev_q;
    logic                  have_prev, burst_done;
    logic [IW-1:0]         idle_cnt;
    logic                  same;

    assign same = have_prev && (frame_data == prev_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q          <= '0;
            have_prev       <= 1'b0;
            burst_done      <= 1'b0;
            idle_cnt        <= '0;
            frame_confirmed <= 1'b0;
        end else begin
            frame_confirmed <= 1'b0;
            if (frame_valid) begin
                frame_confirmed <= same && !burst_done;
                burst_done      <= same;
                prev_q          <= frame_data;
                have_prev       <= 1'b1;
                idle_cnt        <= '0;
            end else if (have_prev) begin
                if (idle_cnt == IDLE_LIM) begin
                    have_prev  <= 1'b0;
                    burst_done <= 1'b0;
                    idle_cnt   <= '0;
                end else begin
                    idle_cnt <= idle_cnt + IW'(1);
                end
            end
        end
    end

    assert_confirm_follows_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_confirmed |-> $past(frame_valid));
    assert_confirm_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_confirmed |=> !frame_confirmed);
endmodule

// File: rtl/ppd_decoder.sv
module ppd_decoder #(
    parameter int FRAME_BITS = 46,
    parameter int PRE_BITS   = 4,
    parameter int CNT_W      = 16,
    parameter int BURST_IDLE = 50000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_in,
    input  logic [CNT_W-1:0]      cfg_glitch,
    input  logic [CNT_W-1:0]      cfg_split,
    input  logic [CNT_W-1:0]      cfg_timeout,
    output logic                  frame_valid,
    output logic [FRAME_BITS-1:0] frame_data,
    output logic                  frame_confirmed
);
    logic rise, sym_valid, sym_bit, abort;

    ppd_edge_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .rx_in (rx_in),
        .rise  (rise)
    );

    ppd_gap_timer #(.CNT_W(CNT_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise        (rise),
        .cfg_glitch  (cfg_glitch),
        .cfg_split   (cfg_split),
        .cfg_timeout (cfg_timeout),
        .sym_valid   (sym_valid),
        .sym_bit     (sym_bit),
        .abort       (abort)
    );

    ppd_frame_asm #(.FRAME_BITS(FRAME_BITS), .PRE_BITS(PRE_BITS)) u_asm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sym_valid   (sym_valid),
        .sym_bit     (sym_bit),
        .abort       (abort),
        .frame_valid (frame_valid),
        .frame_data  (frame_data)
    );

    ppd_repeat_check #(.FRAME_BITS(FRAME_BITS), .BURST_IDLE(BURST_IDLE)) u_rep (
        .clk             (clk),
        .rst_n           (rst_n),
        .frame_valid     (frame_valid),
        .frame_data      (frame_data),
        .frame_confirmed (frame_confirmed)
    );
endmodule

// File: tb/sim_ppd_decoder.sv
module sim_ppd_decoder;
    localparam int FB   = 46;
    localparam int IDLE = 3000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_in = 1'b0;
    logic [15:0]   cfg_glitch = 16'd6, cfg_split = 16'd20, cfg_timeout = 16'd60;
    logic          frame_valid, frame_confirmed;
    logic [FB-1:0] frame_data;

    int n_vec = 0, n_bad = 0;
    int n_frames = 0, n_conf = 0;
    logic [FB-1:0] last_frame = '0;
    logic fv_prev = 1'b0;
    bit finished = 0;

    localparam logic [FB-1:0] FA = {4'hF, 40'h5A3C96E10B, 2'b10};
    localparam logic [FB-1:0] FBB = {4'hF, 40'h5A3C96E10C, 2'b01};
    localparam logic [FB-1:0] FC = {4'hF, 40'h0F1E2D3C4B, 2'b11};

    always #2.5 clk = ~clk;   // 200 MHz

    ppd_decoder #(.FRAME_BITS(FB), .PRE_BITS(4), .CNT_W(16), .BURST_IDLE(IDLE)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in),
        .cfg_glitch(cfg_glitch), .cfg_split(cfg_split), .cfg_timeout(cfg_timeout),
        .frame_valid(frame_valid), .frame_data(frame_data),
        .frame_confirmed(frame_confirmed)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_valid) begin
                n_frames++;
                last_frame = frame_data;
            end
            if (frame_confirmed) n_conf++;
            if (frame_valid && fv_prev)
                check(1'b0, "R6 strobe longer than one cycle", 64'd1, 64'd0);
            fv_prev = frame_valid;
        end
    end

    task automatic hold(input logic v, input int k);
        rx_in = v;
        repeat (k) @(negedge clk);
    endtask

    task automatic pulse_gap(input int gap, input bit glitch);
        hold(1'b1, 3);
        if (glitch) begin
            hold(1'b0, 1);
            hold(1'b1, 1);
            hold(1'b0, gap - 5);
        end else begin
            hold(1'b0, gap - 3);
        end
    endtask

    task automatic send_bits(input logic [63:0] seq, input int n, input int g0,
                             input int g1, input bit glitch);
        for (int i = 0; i < n; i++)
            pulse_gap(seq[63-i] ? g1 : g0, glitch);
        hold(1'b1, 3);
        hold(1'b0, 150);
    endtask

    task automatic send_frame(input logic [FB-1:0] f);
        send_bits({f, 18'b0}, FB, 12, 28, 1'b0);
    endtask

    task automatic settle();
        hold(1'b0, IDLE + 500);
    endtask

    task automatic t_reset();
        check(frame_valid == 1'b0, "R9 frame_valid", {63'd0, frame_valid}, 64'd0);
        check(frame_confirmed == 1'b0, "R9 frame_confirmed", {63'd0, frame_confirmed}, 64'd0);
        check(frame_data == '0, "R9 frame_data", {18'd0, frame_data}, 64'd0);
    endtask

    task automatic t_single();
        int f0, c0;
        settle();
        f0 = n_frames; c0 = n_conf;
        send_frame(FA);
        check(n_frames == f0 + 1, "R6 one frame", 64'(n_frames - f0), 64'd1);
        check(last_frame == FA, "R5 msb-first data", {18'd0, last_frame}, {18'd0, FA});
        check(n_conf == c0, "R7 single frame not confirmed", 64'(n_conf - c0), 64'd0);
        hold(1'b0, 500);
        check(frame_data == FA, "R6 data held", {18'd0, frame_data}, {18'd0, FA});
    endtask

    task automatic t_burst();
        int f0, c0;
        settle();
        f0 = n_frames; c0 = n_conf;
        for (int k = 0; k < 6; k++) send_frame(FA);
        check(n_frames == f0 + 6, "R6 six frames", 64'(n_frames - f0), 64'd6);
        check(n_conf == c0 + 1, "R8 one confirm per burst", 64'(n_conf - c0), 64'd1);
        // R8 re-arm after idle gap
        settle();
        c0 = n_conf;
        send_frame(FA);
        send_frame(FA);
        check(n_conf == c0 + 1, "R8 re-arm after idle", 64'(n_conf - c0), 64'd1);
    endtask

    task automatic t_differ();
        int c0;
        settle();
        c0 = n_conf;
        send_frame(FBB);
        send_frame(FA);
        check(n_conf == c0, "R7 differing frames no confirm", 64'(n_conf - c0), 64'd0);
        send_frame(FA);
        check(n_conf == c0 + 1, "R7 match confirms", 64'(n_conf - c0), 64'd1);
        check(frame_data == FA, "R7 confirmed data", {18'd0, frame_data}, {18'd0, FA});
    endtask

    task automatic t_boundary();
        settle();
        send_bits({FC, 18'b0}, FB, 19, 20, 1'b0);
        check(last_frame == FC, "R1 split boundary 19/20", {18'd0, last_frame}, {18'd0, FC});
    endtask

    task automatic t_glitch();
        int f0;
        settle();
        f0 = n_frames;
        send_bits({FBB, 18'b0}, FB, 12, 28, 1'b1);
        check(n_frames == f0 + 1, "R2 glitched frame count", 64'(n_frames - f0), 64'd1);
        check(last_frame == FBB, "R2 glitch edges ignored", {18'd0, last_frame}, {18'd0, FBB});
    endtask

    task automatic t_timeout();
        int f0;
        settle();
        f0 = n_frames;
        send_bits({FBB, 18'b0}, 20, 12, 28, 1'b0);
        check(n_frames == f0, "R3 partial frame dropped", 64'(n_frames - f0), 64'd0);
        send_frame(FC);
        check(n_frames == f0 + 1, "R3 frame after abort", 64'(n_frames - f0), 64'd1);
        check(last_frame == FC, "R3 clean restart", {18'd0, last_frame}, {18'd0, FC});
    endtask

    task automatic t_preamble();
        int f0;
        settle();
        f0 = n_frames;
        send_bits({4'b0110, FA, 14'b0}, FB + 4, 12, 28, 1'b0);
        check(n_frames == f0 + 1, "R4 frame after leading bits", 64'(n_frames - f0), 64'd1);
        check(last_frame == FA, "R4 leading bits dropped", {18'd0, last_frame}, {18'd0, FA});
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_single();
        t_burst();
        t_differ();
        t_boundary();
        t_glitch();
        t_timeout();
        t_preamble();
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule